// File: doc/BRIEF.md
# Sleep Mode Entry Controller

This controller holds the chip-level low-power state of a small processor subsystem. It watches a one-cycle sleep strobe from the CPU and a deep-sleep select level from the sleep control register. From these it moves between three modes: run, light sleep and deep sleep. In light sleep only the CPU is halted. In deep sleep the CPU is halted with its registers kept, every bus access (memory auto-refresh included) is inhibited and the DMA engine is stopped. Other peripherals keep running and the external clock keeps toggling.

Two 32-bit module-stop registers, written by software, gate individual module clocks in every mode. If deep sleep is entered while a protected module's stop bit is still clear, a sticky flag is raised for software to inspect. The entry goes ahead anyway. Any enabled interrupt request returns the controller to run. Every output comes straight from a register.

Top module: `sleep_entry_ctrl`

## Requirements
- R1: After reset, `status` is 00, `cpu_halt`, `bus_inhibit`, `dma_stop` and `prot_warn` are 0, and all 64 bits of `mod_clk_en` are 1.
- R2: In run mode, a sleep strobe with `deep_sel`=1 makes `status` read 10 one clock later, with `cpu_halt`, `bus_inhibit` and `dma_stop` all 1.
- R3: In run mode, a sleep strobe with `deep_sel`=0 makes `status` read 01 one clock later, with `cpu_halt` 1 and `bus_inhibit` and `dma_stop` 0.
- R4: In light or deep sleep, an interrupt whose `irq_en` bit is 1 makes `status` 00 and clears `cpu_halt`, `bus_inhibit` and `dma_stop` together, one clock later.
- R5: While asleep, interrupts with a clear enable bit and further sleep strobes leave every output unchanged.
- R6: A stop write with `stop_sel`=0 loads bits 31:0 of the stop state, and with `stop_sel`=1 it loads bits 63:32. One clock later `mod_clk_en` equals the bitwise inverse of the stop state. Mode changes never alter `mod_clk_en`.
- R7: A deep-sleep entry while (stop state AND `PROTECT_MASK`) differs from `PROTECT_MASK` sets `prot_warn` one clock later. Light-sleep entry never sets it. `warn_clr` clears it, and a set in the same cycle wins over the clear.
- R8: In run mode an enabled interrupt without a strobe changes nothing. A strobe that arrives together with an interrupt still enters sleep.
- R9: The status encoding is run 00, light sleep 01, deep sleep 10. The value 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_strobe | input | 1 | One-cycle pulse from the CPU's sleep instruction |
| deep_sel | input | 1 | Deep-sleep select bit of the sleep control register |
| stop_wr | input | 1 | Write strobe for a module-stop register |
| stop_sel | input | 1 | 0 selects the low stop word, 1 the high word |
| stop_data | input | 32 | Value written to the selected stop word |
| irq | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line wake enables |
| warn_clr | input | 1 | Clears the protected-module warning flag |
| cpu_halt | output | 1 | Halt request to the CPU (no reset) |
| bus_inhibit | output | 1 | Blocks all bus accesses and refresh requests |
| dma_stop | output | 1 | Stops the DMA engine |
| mod_clk_en | output | 64 | Per-module clock enables, inverse of the stop state |
| status | output | 2 | Current mode code |
| prot_warn | output | 1 | Sticky flag for a deep entry with a protected module running |

## Verification
The hardest case to reach is a deep-sleep entry where the stop state only partly covers the protected set. The flag must then rise. It must stay clear when the coverage is complete, or when only light sleep is entered. The stimulus first loads both stop words with every protected bit set and enters and leaves deep sleep. It then clears one protected bit and enters again. It also writes stop words while asleep and pairs `warn_clr` with a new entry. A random phase then mixes strobes, partial enables and stop writes, and a reference model is compared on every clock.

// File: rtl/sleep_entry_ctrl.sv
module sleep_entry_ctrl #(
  parameter int          NUM_IRQ      = 8,
  parameter logic [63:0] PROTECT_MASK = 64'h0000_0003_0000_0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_strobe,
  input  logic               deep_sel,
  input  logic               stop_wr,
  input  logic               stop_sel,
  input  logic [31:0]        stop_data,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               warn_clr,
  output logic               cpu_halt,
  output logic               bus_inhibit,
  output logic               dma_stop,
  output logic [63:0]        mod_clk_en,
  output logic [1:0]         status,
  output logic               prot_warn
);
  localparam int SW = 32;
  localparam int MW = 2 * SW;

  typedef enum logic [1:0] {M_RUN = 2'b00, M_LIGHT = 2'b01, M_DEEP = 2'b10} mode_t;

  mode_t         mode_q, mode_d;
  logic [MW-1:0] stop_q, stop_d;
  logic          wake, deep_entry, unprotected;

  assign wake        = |(irq & irq_en);
  assign deep_entry  = (mode_q == M_RUN) && sleep_strobe && deep_sel;
  assign unprotected = (stop_q & PROTECT_MASK) != PROTECT_MASK;
  assign status      = mode_q;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == M_RUN) begin
      if (sleep_strobe) mode_d = deep_sel ? M_DEEP : M_LIGHT;
    end else if (wake) begin
      mode_d = M_RUN;
    end
  end

  always_comb begin
    stop_d = stop_q;
    if (stop_wr) begin
      if (stop_sel) stop_d[MW-1:SW] = stop_data;
      else          stop_d[SW-1:0]  = stop_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_RUN;
      stop_q      <= '0;
      cpu_halt    <= 1'b0;
      bus_inhibit <= 1'b0;
      dma_stop    <= 1'b0;
      mod_clk_en  <= '1;
      prot_warn   <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      stop_q      <= stop_d;
      cpu_halt    <= mode_d != M_RUN;
      bus_inhibit <= mode_d == M_DEEP;
      dma_stop    <= mode_d == M_DEEP;
      mod_clk_en  <= ~stop_d;
      if (deep_entry && unprotected) prot_warn <= 1'b1;
      else if (warn_clr)             prot_warn <= 1'b0;
    end
  end

  // R9
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);

  // R2
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00 && sleep_strobe && deep_sel) |=> (status == 2'b10 && cpu_halt && bus_inhibit && dma_stop));

  // R3
  light_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00 && sleep_strobe && !deep_sel) |=> (status == 2'b01 && cpu_halt && !bus_inhibit && !dma_stop));

  // R4
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b00 && wake) |=> (status == 2'b00 && !cpu_halt && !bus_inhibit && !dma_stop));

  // R5
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b00 && !wake) |=> ($stable(status) && $stable(cpu_halt) && $stable(bus_inhibit)));

  // R6
  clk_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_wr |=> $stable(mod_clk_en));

  // R7
  light_no_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_warn && (status != 2'b00 || !deep_sel || !sleep_strobe)) |=> !prot_warn);
endmodule

// File: tb/test_sleep_entry_ctrl.sv
module test_sleep_entry_ctrl;
  localparam int          NI   = 8;
  localparam logic [63:0] MASK = 64'h0000_0003_0000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_strobe = 0, deep_sel = 0, stop_wr = 0, stop_sel = 0, warn_clr = 0;
  logic [31:0] stop_data = '0;
  logic [NI-1:0] irq = '0, irq_en = '0;
  logic cpu_halt, bus_inhibit, dma_stop, prot_warn;
  logic [63:0] mod_clk_en;
  logic [1:0] status;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int          m_mode = 0;
  logic [63:0] m_stop = '0;
  logic        m_warn = 0;

  always #5 clk = ~clk;

  sleep_entry_ctrl #(.NUM_IRQ(NI), .PROTECT_MASK(MASK)) i_sleep_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .deep_sel(deep_sel),
    .stop_wr(stop_wr), .stop_sel(stop_sel), .stop_data(stop_data), .irq(irq),
    .irq_en(irq_en), .warn_clr(warn_clr), .cpu_halt(cpu_halt), .bus_inhibit(bus_inhibit),
    .dma_stop(dma_stop), .mod_clk_en(mod_clk_en), .status(status), .prot_warn(prot_warn));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_stop = '0; m_warn = 0;
    end else begin
      int nm;
      nm = m_mode;
      if (m_mode == 0 && sleep_strobe) nm = deep_sel ? 2 : 1;
      else if (m_mode != 0 && (irq & irq_en) != 0) nm = 0;
      if (m_mode == 0 && sleep_strobe && deep_sel && ((m_stop & MASK) != MASK)) m_warn = 1;
      else if (warn_clr) m_warn = 0;
      if (stop_wr) begin
        if (stop_sel) m_stop[63:32] = stop_data;
        else          m_stop[31:0]  = stop_data;
      end
      m_mode = nm;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req == "" ? "R9" : req, "status", 64'(status), 64'(m_mode));
    chk(req == "" ? "R2" : req, "cpu_halt", 64'(cpu_halt), 64'(m_mode != 0));
    chk(req == "" ? "R2" : req, "bus_inhibit", 64'(bus_inhibit), 64'(m_mode == 2));
    chk(req == "" ? "R3" : req, "dma_stop", 64'(dma_stop), 64'(m_mode == 2));
    chk(req == "" ? "R6" : req, "mod_clk_en", mod_clk_en, ~m_stop);
    chk(req == "" ? "R7" : req, "prot_warn", 64'(prot_warn), 64'(m_warn));
  endtask

  task automatic step(string req);
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
    sleep_strobe = 0; stop_wr = 0; warn_clr = 0; irq = '0;
  endtask

  task automatic wr_stop(bit sel, logic [31:0] d, string req);
    stop_wr = 1; stop_sel = sel; stop_data = d;
    step(req);
  endtask

  task automatic strobe(bit deep, string req);
    sleep_strobe = 1; deep_sel = deep;
    step(req);
  endtask

  initial begin
    #100000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");
    chk("R1", "reset clk_en", mod_clk_en, '1);
    rst_n = 1;
    step("R1");
    wr_stop(0, 32'h0000_01F0, "R6");
    wr_stop(1, 32'h0000_0003, "R6");
    chk("R6", "clk_en value", mod_clk_en, ~64'h0000_0003_0000_01F0);
    strobe(1, "R2");
    chk("R2", "deep status", 64'(status), 64'd2);
    chk("R7", "no warn when covered", 64'(prot_warn), 64'd0);
    irq = 8'h0F; irq_en = 8'hF0; step("R5");
    chk("R5", "masked irq", 64'(status), 64'd2);
    strobe(0, "R5");
    chk("R5", "strobe while asleep", 64'(status), 64'd2);
    wr_stop(0, 32'h0000_0100, "R6");
    chk("R6", "write in deep", mod_clk_en, ~64'h0000_0003_0000_0100);
    irq = 8'h10; step("R4");
    chk("R4", "wake", 64'({status, cpu_halt, bus_inhibit, dma_stop}), 64'd0);
    irq = 8'hFF; step("R8");
    chk("R8", "irq in run", 64'(status), 64'd0);
    irq = 8'hFF; strobe(0, "R3");
    chk("R8", "strobe with irq", 64'(status), 64'd1);
    chk("R3", "light dma", 64'(dma_stop), 64'd0);
    irq = 8'h80; step("R4");
    wr_stop(1, 32'h0000_0001, "R6");
    strobe(0, "R7");
    chk("R7", "light no warn", 64'(prot_warn), 64'd0);
    irq = 8'h20; step("R4");
    strobe(1, "R7");
    chk("R7", "partial cover warn", 64'(prot_warn), 64'd1);
    irq = 8'h40; step("R4");
    warn_clr = 1; step("R7");
    chk("R7", "cleared", 64'(prot_warn), 64'd0);
    warn_clr = 1; strobe(1, "R7");
    chk("R7", "set beats clear", 64'(prot_warn), 64'd1);
    for (int i = 0; i < 400; i++) begin
      sleep_strobe = ($urandom_range(0, 3) == 0);
      deep_sel     = $urandom_range(0, 1);
      stop_wr      = ($urandom_range(0, 4) == 0);
      stop_sel     = $urandom_range(0, 1);
      stop_data    = $urandom() | (($urandom_range(0, 1) != 0) ? 32'h0000_0103 : 32'h0);
      warn_clr     = ($urandom_range(0, 5) == 0);
      irq          = ($urandom_range(0, 3) == 0) ? NI'($urandom()) : '0;
      irq_en       = NI'($urandom());
      step("");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule